// File: doc/BRIEF.md
# Sync Timing Measurement Unit

This block watches a separate horizontal sync and vertical sync pair and measures both against its own clock. For the line timing it keeps four running values, the shortest and longest line period and the shortest and longest horizontal pulse high time, all in clock cycles. A line starts on each rising edge of the horizontal input. Because the input is sampled with a clock of limited resolution, a minimum and maximum pair is kept rather than a single value. A one-cycle read strobe makes the next completed line reload both ends of each pair.

For the frame timing it counts lines between rising edges of the vertical input and counts the lines on which the vertical input was high. It derives the polarity of both sync signals and detects interlaced timing. It raises sticky flags for a missing horizontal sync, a missing vertical sync, and a line or frame period that jumps by more than a programmable threshold. Each flag is cleared by writing a one to its bit of a clear strobe. When a sync input stops, the last good values stay in place, and the broken interval is never used as a measurement.

Top module: `sync_timing_meas`

## Requirements
- R1: Each line period is the number of clocks between consecutive rising edges of `hsync_i`. `hper_min_o`/`hper_max_o` hold the smallest and largest period seen since the last restart. All measurement outputs and flags read zero after reset.
- R2: The horizontal high time is the number of clocks from a rising edge of `hsync_i` to the following falling edge. `hhi_min_o`/`hhi_max_o` track its smallest and largest value, so `hhi_min_o <= hhi_max_o <= hper_max_o`.
- R3: After a cycle with `hrd_i` high, the next line completed loads both ends of each min/max pair with its own values, and older lines no longer count.
- R4: `hpol_o` is 1 (pulse active high) when twice the high time is strictly less than the period, and 0 otherwise. It is updated every line.
- R5: `vper_o` is the number of `hsync_i` rising edges between consecutive rising edges of `vsync_i`. `vhi_o` is the number of `hsync_i` falling edges (the trailing edge of a positive pulse) at which `vsync_i` was high. Both update on every `vsync_i` rising edge.
- R6: `vpol_o` is 1 when twice `vhi_o` is strictly less than `vper_o`, and 0 otherwise.
- R7: `hs_miss_o` (clear bit 0) sets when `HS_TIMEOUT` clocks pass with no `hsync_i` rising edge. The interval that spans the gap is not used as a line, and the min/max values hold.
- R8: `vs_miss_o` (clear bit 1) sets when `VS_TIMEOUT` clocks pass with no `vsync_i` rising edge. `vper_o`/`vhi_o` hold, and the first frame edge after the gap only restarts counting.
- R9: `chg_o` (clear bit 2) sets when the difference between a line period and the previous line period is strictly greater than `hthr_i`.
- R10: `chg_o` also sets when the difference between a frame period and the previous frame period is strictly greater than `vthr_i`.
- R11: `intl_o` is 1 when the most recent frame period differs from the one before it by exactly one line, and 0 otherwise.
- R12: The flags are sticky. A one in `flag_clr_i` clears its flag, but a condition that still holds in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Measurement reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync, asynchronous |
| vsync_i | input | 1 | Vertical sync, asynchronous |
| hrd_i | input | 1 | Read strobe, restarts the min/max pairs |
| flag_clr_i | input | 3 | Write-one-to-clear: bit0 hs missing, bit1 vs missing, bit2 change |
| hthr_i | input | HW | Line period change threshold, clocks |
| vthr_i | input | VW | Frame period change threshold, lines |
| hper_min_o | output | HW | Shortest line period |
| hper_max_o | output | HW | Longest line period |
| hhi_min_o | output | HW | Shortest horizontal high time |
| hhi_max_o | output | HW | Longest horizontal high time |
| hpol_o | output | 1 | Horizontal polarity, 1 = active high |
| vper_o | output | VW | Frame period in lines |
| vhi_o | output | VW | Vertical high time in lines |
| vpol_o | output | 1 | Vertical polarity, 1 = active high |
| hs_miss_o | output | 1 | Sticky horizontal sync missing flag |
| vs_miss_o | output | 1 | Sticky vertical sync missing flag |
| chg_o | output | 1 | Sticky timing change flag |
| intl_o | output | 1 | Interlace detected |

## Verification
The properties assume that the min/max pairs are only ever loaded from whole lines, so a high time can never exceed its own period. They also assume the sticky flags change only through a set condition or a clear bit. The stimulus drives both sync inputs on the falling clock edge. Vertical edges are placed in the middle of the horizontal low time, well away from any horizontal edge. Line periods stay below the horizontal timeout except in the deliberate gap test. Read and clear strobes are issued in the last cycle of a line, after the previous line has been committed, so line lengths stay exact.

// File: rtl/stm_pkg.sv
package stm_pkg;

    localparam int FLG_HMISS = 0;
    localparam int FLG_VMISS = 1;
    localparam int FLG_CHG   = 2;
    localparam int FLG_N     = 3;

    typedef struct packed {
        logic chg;
        logic vs_miss;
        logic hs_miss;
    } stm_flags_t;

endpackage

// File: rtl/stm_sync.sv
module stm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic lvl_o,
    output logic prev_o
);
    localparam int CW = STAGES + 1;

    logic [CW-1:0] chain_d, chain_q;

    always_comb chain_d[0] = d_i;

    for (genvar gi = 1; gi < CW; gi++) begin : g_stage
        always_comb chain_d[gi] = chain_q[gi-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/stm_horiz.sv
module stm_horiz #(
    parameter int HW         = 12,
    parameter int HS_TIMEOUT = 4096
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          rise_i,
    input  logic          fall_i,
    input  logic          rd_i,
    input  logic [HW-1:0] thr_i,
    output logic [HW-1:0] per_min_o,
    output logic [HW-1:0] per_max_o,
    output logic [HW-1:0] hi_min_o,
    output logic [HW-1:0] hi_max_o,
    output logic          pol_o,
    output logic          chg_o,
    output logic          miss_o
);
    localparam logic [HW-1:0] TO_M1 = HW'(HS_TIMEOUT - 1);

    typedef struct packed {
        logic [HW-1:0] cnt;
        logic [HW-1:0] hi_last;
        logic          valid;
        logic          hi_seen;
        logic          empty;
        logic [HW-1:0] per_min;
        logic [HW-1:0] per_max;
        logic [HW-1:0] hi_min;
        logic [HW-1:0] hi_max;
        logic          pol;
        logic [HW-1:0] prev_per;
        logic          prev_ok;
    } hstate_t;

    hstate_t s_d, s_q;
    logic [HW-1:0] per_now, delta;
    logic [HW:0]   hi_x2;
    logic          restart, cnt_full;

    always_comb begin
        s_d      = s_q;
        chg_o    = 1'b0;
        miss_o   = 1'b0;
        cnt_full = &s_q.cnt;
        per_now  = cnt_full ? s_q.cnt : s_q.cnt + 1'b1;
        restart  = rd_i || s_q.empty;
        hi_x2    = {s_q.hi_last, 1'b0};
        delta    = (per_now > s_q.prev_per) ? per_now - s_q.prev_per
                                            : s_q.prev_per - per_now;
        if (rd_i) s_d.empty = 1'b1;

        if (rise_i) begin
            if (s_q.valid && s_q.hi_seen) begin
                if (restart) begin
                    s_d.per_min = per_now;
                    s_d.per_max = per_now;
                    s_d.hi_min  = s_q.hi_last;
                    s_d.hi_max  = s_q.hi_last;
                end else begin
                    if (per_now < s_q.per_min)     s_d.per_min = per_now;
                    if (per_now > s_q.per_max)     s_d.per_max = per_now;
                    if (s_q.hi_last < s_q.hi_min)  s_d.hi_min  = s_q.hi_last;
                    if (s_q.hi_last > s_q.hi_max)  s_d.hi_max  = s_q.hi_last;
                end
                s_d.empty    = 1'b0;
                s_d.pol      = hi_x2 < {1'b0, per_now};
                chg_o        = s_q.prev_ok && (delta > thr_i);
                s_d.prev_per = per_now;
                s_d.prev_ok  = 1'b1;
            end
            s_d.cnt     = '0;
            s_d.valid   = 1'b1;
            s_d.hi_seen = 1'b0;
        end else begin
            if (fall_i && s_q.valid) begin
                s_d.hi_last = per_now;
                s_d.hi_seen = 1'b1;
            end
            if (!cnt_full) s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt >= TO_M1) begin
                miss_o      = 1'b1;
                s_d.valid   = 1'b0;
                s_d.prev_ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q       <= '0;
            s_q.empty <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign per_min_o = s_q.per_min;
    assign per_max_o = s_q.per_max;
    assign hi_min_o  = s_q.hi_min;
    assign hi_max_o  = s_q.hi_max;
    assign pol_o     = s_q.pol;
endmodule

// File: rtl/stm_vert.sv
module stm_vert #(
    parameter int VW         = 11,
    parameter int VS_TIMEOUT = 2000000
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          hs_rise_i,
    input  logic          hs_fall_i,
    input  logic          vs_rise_i,
    input  logic          vs_lvl_i,
    input  logic [VW-1:0] thr_i,
    output logic [VW-1:0] per_o,
    output logic [VW-1:0] hi_o,
    output logic          pol_o,
    output logic          intl_o,
    output logic          chg_o,
    output logic          miss_o
);
    localparam int             VTW   = $clog2(VS_TIMEOUT + 1);
    localparam logic [VTW-1:0] TO_M1 = VTW'(VS_TIMEOUT - 1);

    typedef struct packed {
        logic [VW-1:0]  lcnt;
        logic [VW-1:0]  hcnt;
        logic [VTW-1:0] tcnt;
        logic           valid;
        logic           has_per;
        logic [VW-1:0]  per;
        logic [VW-1:0]  hi;
        logic           pol;
        logic           intl;
    } vstate_t;

    vstate_t s_d, s_q;
    logic [VW-1:0] lines_now, hi_now, delta;
    logic [VW:0]   hi_x2;

    always_comb begin
        s_d       = s_q;
        chg_o     = 1'b0;
        miss_o    = 1'b0;
        lines_now = (hs_rise_i && !(&s_q.lcnt)) ? s_q.lcnt + 1'b1 : s_q.lcnt;
        hi_now    = (hs_fall_i && vs_lvl_i && !(&s_q.hcnt)) ? s_q.hcnt + 1'b1 : s_q.hcnt;
        hi_x2     = {hi_now, 1'b0};
        delta     = (lines_now > s_q.per) ? lines_now - s_q.per : s_q.per - lines_now;

        if (vs_rise_i) begin
            if (s_q.valid) begin
                s_d.per     = lines_now;
                s_d.hi      = hi_now;
                s_d.pol     = hi_x2 < {1'b0, lines_now};
                s_d.intl    = s_q.has_per && (delta == VW'(1));
                chg_o       = s_q.has_per && (delta > thr_i);
                s_d.has_per = 1'b1;
            end
            s_d.lcnt  = '0;
            s_d.hcnt  = '0;
            s_d.tcnt  = '0;
            s_d.valid = 1'b1;
        end else begin
            s_d.lcnt = lines_now;
            s_d.hcnt = hi_now;
            if (s_q.tcnt < TO_M1) s_d.tcnt = s_q.tcnt + 1'b1;
            if (s_q.tcnt >= TO_M1) begin
                miss_o      = 1'b1;
                s_d.valid   = 1'b0;
                s_d.has_per = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign per_o  = s_q.per;
    assign hi_o   = s_q.hi;
    assign pol_o  = s_q.pol;
    assign intl_o = s_q.intl;
endmodule

// File: rtl/sync_timing_meas.sv
module sync_timing_meas
    import stm_pkg::*;
#(
    parameter int HW          = 12,
    parameter int VW          = 11,
    parameter int HS_TIMEOUT  = 4096,
    parameter int VS_TIMEOUT  = 2000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          hsync_i,
    input  logic          vsync_i,
    input  logic          hrd_i,
    input  logic [2:0]    flag_clr_i,
    input  logic [HW-1:0] hthr_i,
    input  logic [VW-1:0] vthr_i,
    output logic [HW-1:0] hper_min_o,
    output logic [HW-1:0] hper_max_o,
    output logic [HW-1:0] hhi_min_o,
    output logic [HW-1:0] hhi_max_o,
    output logic          hpol_o,
    output logic [VW-1:0] vper_o,
    output logic [VW-1:0] vhi_o,
    output logic          vpol_o,
    output logic          hs_miss_o,
    output logic          vs_miss_o,
    output logic          chg_o,
    output logic          intl_o
);
    logic hs_lvl, hs_prev, vs_lvl, vs_prev;
    logic hs_rise, hs_fall, vs_rise;
    logic h_chg, h_miss, v_chg, v_miss;
    stm_flags_t flg_d, flg_q;

    stm_sync #(.STAGES(SYNC_STAGES)) u_hs_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hsync_i), .lvl_o(hs_lvl), .prev_o(hs_prev)
    );
    stm_sync #(.STAGES(SYNC_STAGES)) u_vs_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(vsync_i), .lvl_o(vs_lvl), .prev_o(vs_prev)
    );

    assign hs_rise = hs_lvl & ~hs_prev;
    assign hs_fall = ~hs_lvl & hs_prev;
    assign vs_rise = vs_lvl & ~vs_prev;

    stm_horiz #(.HW(HW), .HS_TIMEOUT(HS_TIMEOUT)) u_horiz (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .rise_i(hs_rise), .fall_i(hs_fall), .rd_i(hrd_i), .thr_i(hthr_i),
        .per_min_o(hper_min_o), .per_max_o(hper_max_o),
        .hi_min_o(hhi_min_o), .hi_max_o(hhi_max_o),
        .pol_o(hpol_o), .chg_o(h_chg), .miss_o(h_miss)
    );

    stm_vert #(.VW(VW), .VS_TIMEOUT(VS_TIMEOUT)) u_vert (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .hs_rise_i(hs_rise), .hs_fall_i(hs_fall), .vs_rise_i(vs_rise), .vs_lvl_i(vs_lvl),
        .thr_i(vthr_i),
        .per_o(vper_o), .hi_o(vhi_o), .pol_o(vpol_o), .intl_o(intl_o),
        .chg_o(v_chg), .miss_o(v_miss)
    );

    always_comb begin
        flg_d         = flg_q;
        flg_d.hs_miss = h_miss | (flg_q.hs_miss & ~flag_clr_i[FLG_HMISS]);
        flg_d.vs_miss = v_miss | (flg_q.vs_miss & ~flag_clr_i[FLG_VMISS]);
        flg_d.chg     = h_chg | v_chg | (flg_q.chg & ~flag_clr_i[FLG_CHG]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flg_q <= '0;
        else         flg_q <= flg_d;
    end

    assign hs_miss_o = flg_q.hs_miss;
    assign vs_miss_o = flg_q.vs_miss;
    assign chg_o     = flg_q.chg;
endmodule

// File: rtl/stm_checker.sv
module stm_checker #(
    parameter int HW = 12
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [2:0]    flag_clr_i,
    input logic [HW-1:0] hper_min_o,
    input logic [HW-1:0] hper_max_o,
    input logic [HW-1:0] hhi_min_o,
    input logic [HW-1:0] hhi_max_o,
    input logic          hs_miss_o,
    input logic          vs_miss_o,
    input logic          chg_o
);
    p_per_order_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hper_min_o <= hper_max_o);

    p_hi_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hhi_min_o <= hhi_max_o);

    p_hi_in_line_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hhi_max_o <= hper_max_o);

    p_hmiss_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hs_miss_o && !flag_clr_i[0]) |=> hs_miss_o);

    p_vmiss_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vs_miss_o && !flag_clr_i[1]) |=> vs_miss_o);

    p_chg_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chg_o && !flag_clr_i[2]) |=> chg_o);
endmodule

bind sync_timing_meas stm_checker #(.HW(HW)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .flag_clr_i(flag_clr_i),
    .hper_min_o(hper_min_o), .hper_max_o(hper_max_o),
    .hhi_min_o(hhi_min_o), .hhi_max_o(hhi_max_o),
    .hs_miss_o(hs_miss_o), .vs_miss_o(vs_miss_o), .chg_o(chg_o)
);

// File: tb/sync_timing_meas_tb_top.sv
module sync_timing_meas_tb_top;
    localparam int HW = 12;
    localparam int VW = 11;
    localparam int NT = 5;
    // period, high time, lines after restart, expected polarity
    localparam int TBL [NT][4] = '{
        '{40, 8, 4, 1},
        '{60, 40, 3, 0},
        '{100, 20, 5, 1},
        '{33, 16, 4, 1},
        '{32, 16, 3, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync = 1'b0, vsync = 1'b0, hrd = 1'b0;
    logic [2:0] flag_clr = '0;
    logic [HW-1:0] hthr = '1;
    logic [VW-1:0] vthr = VW'(3);
    logic [HW-1:0] hper_min, hper_max, hhi_min, hhi_max;
    logic [VW-1:0] vper, vhi;
    logic hpol, vpol, hs_miss, vs_miss, chg, intl;
    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sync_timing_meas #(.HW(HW), .VW(VW), .HS_TIMEOUT(256), .VS_TIMEOUT(3000)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .hsync_i(hsync), .vsync_i(vsync), .hrd_i(hrd),
        .flag_clr_i(flag_clr), .hthr_i(hthr), .vthr_i(vthr),
        .hper_min_o(hper_min), .hper_max_o(hper_max), .hhi_min_o(hhi_min), .hhi_max_o(hhi_max),
        .hpol_o(hpol), .vper_o(vper), .vhi_o(vhi), .vpol_o(vpol),
        .hs_miss_o(hs_miss), .vs_miss_o(vs_miss), .chg_o(chg), .intl_o(intl)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic line(input int p, input int h, input bit vs, input bit rd,
                        input logic [2:0] clr);
        int lo;
        lo = p - h;
        hsync = 1'b1;
        repeat (h) @(negedge clk);
        hsync = 1'b0;
        repeat (lo / 2) @(negedge clk);
        vsync = vs;
        repeat (lo - lo / 2 - 1) @(negedge clk);
        hrd = rd;
        flag_clr = clr;
        @(negedge clk);
        hrd = 1'b0;
        flag_clr = '0;
    endtask

    task automatic frame(input int n, input int v);
        for (int i = 0; i < n; i++) line(20, 4, i < v, 1'b0, 3'b000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset hper_max", int'(hper_max), 0);
        chk("R1 reset hhi_max", int'(hhi_max), 0);
        chk("R1 reset vper", int'(vper), 0);
        chk("R1 reset flags", int'({hs_miss, vs_miss, chg, intl}), 0);

        // vector table: restart, steady lines, then expect exact pairs
        for (int e = 0; e < NT; e++) begin
            line(TBL[e][0], TBL[e][1], 1'b0, 1'b1, 3'b000);
            for (int k = 0; k < TBL[e][2]; k++) line(TBL[e][0], TBL[e][1], 1'b0, 1'b0, 3'b000);
            chk("R1 table per min", int'(hper_min), TBL[e][0]);
            chk("R1 table per max", int'(hper_max), TBL[e][0]);
            chk("R2 table hi min", int'(hhi_min), TBL[e][1]);
            chk("R2 table hi max", int'(hhi_max), TBL[e][1]);
            chk("R4 table polarity", int'(hpol), TBL[e][3]);
        end

        // R1 R2: mixed lines accumulate
        line(40, 8, 1'b0, 1'b1, 3'b000);
        line(50, 10, 1'b0, 1'b0, 3'b000);
        line(30, 6, 1'b0, 1'b0, 3'b000);
        line(44, 12, 1'b0, 1'b0, 3'b000);
        line(40, 8, 1'b0, 1'b0, 3'b000);
        chk("R1 mixed min", int'(hper_min), 30);
        chk("R1 mixed max", int'(hper_max), 50);
        chk("R2 mixed hi min", int'(hhi_min), 6);
        chk("R2 mixed hi max", int'(hhi_max), 12);

        // R3: restart drops older extremes
        line(35, 7, 1'b0, 1'b1, 3'b000);
        line(35, 7, 1'b0, 1'b0, 3'b000);
        chk("R3 restart min", int'(hper_min), 35);
        chk("R3 restart max", int'(hper_max), 35);
        chk("R3 restart hi max", int'(hhi_max), 7);

        // R9: horizontal change threshold
        hthr = HW'(5);
        line(40, 8, 1'b0, 1'b0, 3'b000);
        line(40, 8, 1'b0, 1'b0, 3'b100);
        line(40, 8, 1'b0, 1'b0, 3'b000);
        line(40, 8, 1'b0, 1'b0, 3'b000);
        chk("R9 steady no change", int'(chg), 0);
        line(45, 8, 1'b0, 1'b0, 3'b000);
        line(45, 8, 1'b0, 1'b0, 3'b000);
        chk("R9 delta equal threshold", int'(chg), 0);
        line(51, 8, 1'b0, 1'b0, 3'b000);
        line(51, 8, 1'b0, 1'b0, 3'b000);
        chk("R9 delta above threshold", int'(chg), 1);
        line(51, 8, 1'b0, 1'b0, 3'b100);
        chk("R12 change cleared", int'(chg), 0);
        hthr = '1;

        // R5 R6: vertical counts and polarity
        frame(10, 2); frame(10, 2); frame(10, 2);
        chk("R5 frame lines", int'(vper), 10);
        chk("R5 high lines", int'(vhi), 2);
        chk("R6 polarity positive", int'(vpol), 1);
        chk("R10 steady frames no change", int'(chg), 0);
        chk("R11 steady not interlaced", int'(intl), 0);
        frame(10, 7); frame(10, 7); frame(10, 7);
        chk("R5 high lines long", int'(vhi), 7);
        chk("R6 polarity negative", int'(vpol), 0);

        // R11: one-line alternation
        frame(11, 2); frame(10, 2);
        chk("R11 interlace seen", int'(intl), 1);
        chk("R10 one line under threshold", int'(chg), 0);
        frame(10, 2); frame(10, 2);
        chk("R11 interlace gone", int'(intl), 0);

        // R10: frame jump above threshold
        frame(15, 2); frame(10, 2);
        chk("R10 frame jump", int'(chg), 1);
        chk("R10 frame jump period", int'(vper), 15);
        chk("R11 large jump not interlace", int'(intl), 0);

        // R7: horizontal gap
        line(20, 4, 1'b0, 1'b1, 3'b000);
        line(20, 4, 1'b0, 1'b0, 3'b000);
        line(20, 4, 1'b0, 1'b0, 3'b000);
        hsync = 1'b0;
        repeat (280) @(negedge clk);
        flag_clr = 3'b001;
        @(negedge clk);
        flag_clr = '0;
        repeat (20) @(negedge clk);
        chk("R7 missing set", int'(hs_miss), 1);
        chk("R12 live condition beats clear", int'(hs_miss), 1);
        chk("R7 hold during gap", int'(hper_max), 20);
        line(60, 10, 1'b0, 1'b0, 3'b000);
        line(60, 10, 1'b0, 1'b0, 3'b000);
        chk("R7 gap not measured max", int'(hper_max), 60);
        chk("R7 gap not measured min", int'(hper_min), 20);
        line(20, 4, 1'b0, 1'b0, 3'b001);
        chk("R12 hs missing cleared", int'(hs_miss), 0);

        // R8: vertical gap
        for (int i = 0; i < 150; i++) line(20, 4, 1'b0, 1'b0, 3'b000);
        chk("R8 vs missing set", int'(vs_miss), 1);
        chk("R8 hold period", int'(vper), 15);
        frame(12, 2);
        chk("R8 first edge only restarts", int'(vper), 15);
        frame(12, 2);
        chk("R8 resumed period", int'(vper), 12);
        line(20, 4, 1'b0, 1'b0, 3'b111);
        chk("R12 all flags cleared", int'({hs_miss, vs_miss, chg}), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule